// File: doc/BRIEF.md
# Dual Warp Issue Scheduler

This block decides, once per clock, which resident warps of one compute cluster send their next instruction to the execution hardware. Two picker slices work side by side. Slice 0 serves the even-numbered warps and slice 1 serves the odd-numbered ones. Each slice can issue at most one instruction per cycle. Both slices share four execution groups: two 16-lane core groups, one 16-lane memory (load/store) group and one 4-lane special-function group. A 32-thread instruction ties up a group for as many cycles as it takes to push all threads through its lanes.

The surrounding logic marks a warp as ready and gives the class of its next instruction. The block answers with up to two grants per cycle, each with a warp number and a target group. A granted warp waits until it is marked ready again. Warps are not checked against each other, and moving from one warp to another costs no cycle.

Top module: `dual_warp_issue`

## Requirements
- R1: While reset is held and on the first cycle after it, neither issue port is valid, `warp_pending` is all zero and `grp_busy` is all zero.
- R2: A pulse on `rdy_set[w]` sets `warp_pending[w]` on the next clock and stores the class on `rdy_cls[2w+1:2w]`: 00 is arithmetic, 01 is memory, 10 and 11 are special function. The earliest issue of that warp is in the cycle after the pulse.
- R3: Port 0 (`iss0_*`) only grants even warp numbers. Port 1 (`iss1_*`) only grants odd warp numbers.
- R4: Group codes are 0 for core A, 1 for core B, 2 for memory and 3 for special function. An arithmetic instruction goes to core A when A is free, and otherwise to core B. Memory goes to group 2. Special function goes to group 3.
- R5: A core group or the memory group accepts a new instruction 2 cycles after an issue to it. The special-function group accepts one 8 cycles after an issue. Bit g of `grp_busy` is high in each cycle between an issue to group g and the cycle in which it can accept again.
- R6: Two grants in the same cycle always name different groups. Any two classes can pair in one cycle, and two arithmetic instructions go to cores A and B when both are free.
- R7: When both slices want one group that only one of them can have, only one slice issues that cycle. Such a clash is a pair of memory instructions, a pair of special-function instructions, or a pair of arithmetic instructions with a single core free. Slice 0 wins the first clash of each class after reset, and the winner then alternates per class. The losing warp keeps its pending flag.
- R8: Within a slice, the warp after the last granted one, counting upward and wrapping, has the highest priority among eligible warps.
- R9: A grant clears the warp's pending flag. A `rdy_set` pulse in the same cycle as the grant leaves the flag set.
- R10: A slice can grant different warps in consecutive cycles with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rdy_set | input | NUM_WARPS | Per-warp pulse: the next instruction is ready |
| rdy_cls | input | 2*NUM_WARPS | Per-warp class code, captured when the warp's `rdy_set` bit is high |
| warp_pending | output | NUM_WARPS | Per-warp ready flag held by the block |
| iss0_valid | output | 1 | Slice 0 issues this cycle |
| iss0_warp | output | $clog2(NUM_WARPS) | Warp granted by slice 0 |
| iss0_grp | output | 2 | Target group of slice 0 |
| iss1_valid | output | 1 | Slice 1 issues this cycle |
| iss1_warp | output | $clog2(NUM_WARPS) | Warp granted by slice 1 |
| iss1_grp | output | 2 | Target group of slice 1 |
| grp_busy | output | 4 | Per-group occupancy, indexed by group code |

## Verification
The hardest case to reach is the arithmetic clash. Both slices must want a core in a cycle where exactly one core is free, which only happens the cycle after a lone arithmetic issue. The bench reaches it by pulsing one odd and one even arithmetic warp in the exact cycle in which the first warp is granted, so both become pending while core A is still busy. It keeps its own per-class copy of the alternating clash winner to predict which port wins each clash. The round-robin order is checked from a known reset pointer with warp sets chosen so that the next warp in rotation is not the lowest-numbered one.

// File: rtl/dwis_pkg.sv
// Shared types for the dual warp issue scheduler.
// Assumes class codes arrive as 2 bits; code 3 is folded into special function.
package dwis_pkg;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_MEM   = 2'd1,
        CLS_SFX   = 2'd2
    } op_class_e;

    typedef enum logic [1:0] {
        GRP_CORE_A = 2'd0,
        GRP_CORE_B = 2'd1,
        GRP_MEM    = 2'd2,
        GRP_SFX    = 2'd3
    } exec_grp_e;

    // Map a raw class code onto the three legal classes.
    function automatic op_class_e norm_class(input logic [1:0] code);
        case (code)
            2'd0:    return CLS_ARITH;
            2'd1:    return CLS_MEM;
            default: return CLS_SFX;
        endcase
    endfunction

    // Group an instruction of class c lands on, given whether core A is free.
    function automatic exec_grp_e grp_for(input op_class_e c, input logic a_free);
        case (c)
            CLS_ARITH: return a_free ? GRP_CORE_A : GRP_CORE_B;
            CLS_MEM:   return GRP_MEM;
            default:   return GRP_SFX;
        endcase
    endfunction

endpackage

// File: rtl/exec_busy_ctr.sv
// Occupancy counter for one execution group.
// An issue loads CYCLES-1; the group is free again when the count reaches zero.
// Assumes start is only raised while the group is free.
module exec_busy_ctr #(
    parameter int CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic free
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic [CW-1:0] cnt;

    // Load on issue, then count down to idle.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (start)        cnt <= CW'(CYCLES - 1);
        else if (cnt != '0)    cnt <= cnt - 1'b1;
    end

    assign free = (cnt == '0);
endmodule

// File: rtl/rr_picker.sv
// Round-robin selector over N request lines.
// The search starts one past the last accepted index and wraps.
// The pointer only moves when take is high, so an unused pick keeps its turn.
module rr_picker #(
    parameter int N = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          any,
    output logic [IW-1:0] idx
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;

    // First requesting index after ptr, wrapping.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = 0; i < N; i++) begin
            int cand;
            cand = int'(ptr) + 1 + i;
            if (cand >= N) cand = cand - N;
            if (!any && req[IW'(cand)]) begin
                any = 1'b1;
                idx = IW'(cand);
            end
        end
    end

    // Move the pointer to the accepted index.
    always_ff @(posedge clk) begin
        if (!rst_n)            ptr <= IW'(N - 1);
        else if (take && any)  ptr <= idx;
    end
endmodule

// File: rtl/warp_slice_pick.sv
// One scheduler slice. It owns warps whose number has parity SLICE.
// A warp is eligible when it is pending and a group for its class is free.
// It offers one candidate per cycle; the top decides whether it issues.
module warp_slice_pick
    import dwis_pkg::*;
#(
    parameter int NUM_WARPS = 48,
    parameter int SLICE     = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_WARPS-1:0] pending,
    input  op_class_e            cls [NUM_WARPS],
    input  logic [3:0]           grp_free,
    input  logic                 take,
    output logic                 pick_valid,
    output logic [WID-1:0]       pick_warp,
    output op_class_e            pick_cls
);
    localparam int WID = $clog2(NUM_WARPS);
    localparam int NL  = NUM_WARPS / 2;
    localparam int LW  = (NL > 1) ? $clog2(NL) : 1;

    logic [NL-1:0] elig;
    logic [LW-1:0] loc_idx;

    // Per owned warp: pending and a group for its class is free.
    for (genvar l = 0; l < NL; l++) begin : g_elig
        localparam int GW = 2 * l + SLICE;
        always_comb begin
            case (cls[GW])
                CLS_ARITH: elig[l] = pending[GW] && (grp_free[GRP_CORE_A] || grp_free[GRP_CORE_B]);
                CLS_MEM:   elig[l] = pending[GW] && grp_free[GRP_MEM];
                default:   elig[l] = pending[GW] && grp_free[GRP_SFX];
            endcase
        end
    end

    rr_picker #(.N(NL)) u_rr (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (elig),
        .take  (take),
        .any   (pick_valid),
        .idx   (loc_idx)
    );

    // Turn the local index back into a global warp number.
    always_comb begin
        pick_warp = WID'(2 * int'(loc_idx) + SLICE);
        pick_cls  = cls[pick_warp];
    end
endmodule

// File: rtl/dual_warp_issue.sv
// Dual-slice warp issue scheduler for one compute cluster.
// Holds per-warp ready flags and classes, runs two slice pickers, resolves
// group clashes with a per-class alternating winner, and tracks group
// occupancy. Assumes NUM_WARPS is even and WARP_THREADS is a multiple of
// every lane count.
module dual_warp_issue
    import dwis_pkg::*;
#(
    parameter int NUM_WARPS    = 48,
    parameter int WARP_THREADS = 32,
    parameter int CORE_LANES   = 16,
    parameter int MEM_LANES    = 16,
    parameter int SFX_LANES    = 4,
    localparam int WID         = $clog2(NUM_WARPS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_WARPS-1:0]   rdy_set,
    input  logic [2*NUM_WARPS-1:0] rdy_cls,
    output logic [NUM_WARPS-1:0]   warp_pending,
    output logic                   iss0_valid,
    output logic [WID-1:0]         iss0_warp,
    output logic [1:0]             iss0_grp,
    output logic                   iss1_valid,
    output logic [WID-1:0]         iss1_warp,
    output logic [1:0]             iss1_grp,
    output logic [3:0]             grp_busy
);
    localparam int CORE_CYC = WARP_THREADS / CORE_LANES;
    localparam int MEM_CYC  = WARP_THREADS / MEM_LANES;
    localparam int SFX_CYC  = WARP_THREADS / SFX_LANES;

    logic [NUM_WARPS-1:0] pend_q;
    op_class_e            cls_q [NUM_WARPS];
    logic [NUM_WARPS-1:0] granted;
    logic [2:0]           clash_pri;
    logic [3:0]           grp_free;
    logic [3:0]           grp_start;

    logic       pick_v [2];
    logic [WID-1:0] pick_w [2];
    op_class_e  pick_c [2];
    logic       take   [2];

    logic       clash;
    logic       win0, win1;
    exec_grp_e  grp0, grp1;

    // Per-warp ready flag and class register.
    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        assign granted[w] = (iss0_valid && iss0_warp == WID'(w))
                         || (iss1_valid && iss1_warp == WID'(w));

        // Set on a ready pulse (capturing the class), clear on a grant.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q[w] <= 1'b0;
                cls_q[w]  <= CLS_ARITH;
            end else if (rdy_set[w]) begin
                pend_q[w] <= 1'b1;
                cls_q[w]  <= norm_class(rdy_cls[2*w +: 2]);
            end else if (granted[w]) begin
                pend_q[w] <= 1'b0;
            end
        end
    end

    // Two slice pickers, one per warp parity.
    for (genvar s = 0; s < 2; s++) begin : g_slice
        warp_slice_pick #(
            .NUM_WARPS (NUM_WARPS),
            .SLICE     (s)
        ) u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .pending    (pend_q),
            .cls        (cls_q),
            .grp_free   (grp_free),
            .take       (take[s]),
            .pick_valid (pick_v[s]),
            .pick_warp  (pick_w[s]),
            .pick_cls   (pick_c[s])
        );
    end

    // Settle clashes between the two slice candidates and pick groups.
    always_comb begin
        clash = pick_v[0] && pick_v[1] && (pick_c[0] == pick_c[1])
             && !(pick_c[0] == CLS_ARITH && grp_free[GRP_CORE_A] && grp_free[GRP_CORE_B]);
        win0  = pick_v[0] && (!clash || !clash_pri[pick_c[0]]);
        win1  = pick_v[1] && (!clash ||  clash_pri[pick_c[1]]);
        grp0  = grp_for(pick_c[0], grp_free[GRP_CORE_A]);
        if (pick_c[1] == CLS_ARITH && win0 && pick_c[0] == CLS_ARITH)
            grp1 = GRP_CORE_B;
        else
            grp1 = grp_for(pick_c[1], grp_free[GRP_CORE_A]);
        take[0] = win0;
        take[1] = win1;
    end

    // Flip the clash winner of a class each time that class clashes.
    always_ff @(posedge clk) begin
        if (!rst_n)     clash_pri <= '0;
        else if (clash) clash_pri[pick_c[0]] <= ~clash_pri[pick_c[0]];
    end

    // Occupancy counters, lane width sets the hold time.
    for (genvar g = 0; g < 4; g++) begin : g_grp
        localparam int CYC = (g < 2) ? CORE_CYC : ((g == 2) ? MEM_CYC : SFX_CYC);
        assign grp_start[g] = (win0 && grp0 == exec_grp_e'(g))
                           || (win1 && grp1 == exec_grp_e'(g));
        exec_busy_ctr #(.CYCLES(CYC)) u_busy (
            .clk   (clk),
            .rst_n (rst_n),
            .start (grp_start[g]),
            .free  (grp_free[g])
        );
    end

    assign warp_pending = pend_q;
    assign grp_busy     = ~grp_free;
    assign iss0_valid   = win0;
    assign iss0_warp    = pick_w[0];
    assign iss0_grp     = grp0;
    assign iss1_valid   = win1;
    assign iss1_warp    = pick_w[1];
    assign iss1_grp     = grp1;
endmodule

// File: rtl/dwis_checker.sv
// Property checker for dual_warp_issue, attached by bind.
module dwis_checker #(
    parameter int NUM_WARPS = 48,
    localparam int WID      = $clog2(NUM_WARPS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_WARPS-1:0] rdy_set,
    input logic [NUM_WARPS-1:0] warp_pending,
    input logic                 iss0_valid,
    input logic [WID-1:0]       iss0_warp,
    input logic [1:0]           iss0_grp,
    input logic                 iss1_valid,
    input logic [WID-1:0]       iss1_warp,
    input logic [1:0]           iss1_grp,
    input logic [3:0]           grp_busy
);
    // R6
    dual_grp_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss0_valid && iss1_valid) |-> (iss0_grp != iss1_grp));

    // R3
    slice0_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss0_valid |-> (iss0_warp[0] == 1'b0));

    // R3
    slice1_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_valid |-> (iss1_warp[0] == 1'b1));

    // R5
    iss0_free_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss0_valid |-> !grp_busy[iss0_grp]);

    // R5
    iss1_free_grp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_valid |-> !grp_busy[iss1_grp]);

    // R5
    iss0_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss0_valid |=> grp_busy[$past(iss0_grp)]);

    // R2
    iss0_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss0_valid |-> warp_pending[iss0_warp]);

    // R2
    iss1_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_valid |-> warp_pending[iss1_warp]);

    // R9
    iss0_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss0_valid && !rdy_set[iss0_warp]) |=> !warp_pending[$past(iss0_warp)]);

    // R9
    iss1_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss1_valid && !rdy_set[iss1_warp]) |=> !warp_pending[$past(iss1_warp)]);
endmodule

bind dual_warp_issue dwis_checker #(.NUM_WARPS(NUM_WARPS)) u_dwis_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rdy_set      (rdy_set),
    .warp_pending (warp_pending),
    .iss0_valid   (iss0_valid),
    .iss0_warp    (iss0_warp),
    .iss0_grp     (iss0_grp),
    .iss1_valid   (iss1_valid),
    .iss1_warp    (iss1_warp),
    .iss1_grp     (iss1_grp),
    .grp_busy     (grp_busy)
);

// File: tb/tb_dual_warp_issue.sv
// Bench for dual_warp_issue with eight warps. Inputs change and outputs are
// sampled on the falling edge; grants depend only on registered state.
module tb_dual_warp_issue;
    localparam int W   = 8;
    localparam int WID = $clog2(W);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [W-1:0]   rdy_set = '0;
    logic [2*W-1:0] rdy_cls = '0;
    logic [W-1:0]   warp_pending;
    logic           iss0_valid, iss1_valid;
    logic [WID-1:0] iss0_warp, iss1_warp;
    logic [1:0]     iss0_grp, iss1_grp;
    logic [3:0]     grp_busy;

    int nchk = 0;
    int nfail = 0;
    int pri [3];

    always #2.5 clk = ~clk;

    dual_warp_issue #(.NUM_WARPS(W)) dut (
        .clk(clk), .rst_n(rst_n), .rdy_set(rdy_set), .rdy_cls(rdy_cls),
        .warp_pending(warp_pending),
        .iss0_valid(iss0_valid), .iss0_warp(iss0_warp), .iss0_grp(iss0_grp),
        .iss1_valid(iss1_valid), .iss1_warp(iss1_warp), .iss1_grp(iss1_grp),
        .grp_busy(grp_busy)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_cls(input int w, input int c);
        rdy_cls[2*w +: 2] = 2'(c);
    endtask

    // One-cycle ready pulse; returns on the falling edge after it.
    task automatic pulse(input logic [W-1:0] m);
        rdy_set = m;
        @(negedge clk);
        rdy_set = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        for (int c = 0; c < 3; c++) pri[c] = 0;
    endtask

    function automatic int grp_of(input int c);
        return (c == 0) ? 0 : ((c == 1) ? 2 : 3);
    endfunction

    // Wait up to 20 cycles for a port-0 grant and return its warp.
    task automatic next_iss0(output int warp);
        warp = -1;
        for (int i = 0; i < 20; i++) begin
            if (iss0_valid) begin
                warp = int'(iss0_warp);
                break;
            end
            tick();
        end
    endtask

    // Issue interval of two port-0 warps sharing one class, plus busy count of grp.
    task automatic interval(input int c, input int g, input string req, input int exp);
        int w0, gap, busy_n;
        set_cls(0, c); set_cls(2, c);
        pulse(8'b0000_0101);
        next_iss0(w0);
        chk(req, "first issue seen", int'(w0 >= 0), 1);
        gap = 0; busy_n = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            gap++;
            if (iss0_valid) break;
            if (grp_busy[g]) busy_n++;
        end
        chk(req, "reissue interval", gap, exp);
        chk(req, "busy cycles between", busy_n, exp - 1);
        idle(10);
    endtask

    // Clash of two same-class instructions on warps 0 and 1.
    task automatic clash_pair(input int c, input string req);
        int win, gap;
        set_cls(0, c); set_cls(1, c);
        pulse(8'b0000_0011);
        win = pri[c];
        chk(req, "winner port0 valid", int'(iss0_valid), win == 0 ? 1 : 0);
        chk(req, "winner port1 valid", int'(iss1_valid), win == 1 ? 1 : 0);
        chk(req, "loser keeps pending", int'(warp_pending[win == 0 ? 1 : 0]), 1);
        pri[c] = 1 - pri[c];
        gap = 0;
        for (int i = 0; i < 12; i++) begin
            tick();
            gap++;
            if (iss0_valid || iss1_valid) break;
        end
        chk(req, "loser delay", gap, c == 2 ? 8 : 2);
        chk(req, "loser port valid", int'(win == 0 ? iss1_valid : iss0_valid), 1);
        chk(req, "loser group", int'(win == 0 ? iss1_grp : iss0_grp), grp_of(c));
        idle(10);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin : main
        int w;
        // R1: reset state
        rst_n = 1'b0;
        idle(2);
        chk("R1", "pending in reset", int'(warp_pending), 0);
        chk("R1", "busy in reset", int'(grp_busy), 0);
        do_reset();
        chk("R1", "port0 after reset", int'(iss0_valid), 0);
        chk("R1", "port1 after reset", int'(iss1_valid), 0);
        chk("R1", "pending after reset", int'(warp_pending), 0);
        chk("R1", "busy after reset", int'(grp_busy), 0);

        // R2 R3 R4 R9: every warp with every class code, alone
        for (int ww = 0; ww < W; ww++) begin
            for (int c = 0; c < 4; c++) begin
                int cc;
                cc = (c == 3) ? 2 : c;
                set_cls(ww, c);
                rdy_set = W'(1) << ww;
                #1;
                chk("R2", "no issue in pulse cycle", int'(iss0_valid | iss1_valid), 0);
                tick();
                rdy_set = '0;
                chk("R2", "pending set", int'(warp_pending[ww]), 1);
                chk("R3", "owning port valid", int'((ww % 2 == 0) ? iss0_valid : iss1_valid), 1);
                chk("R3", "other port idle", int'((ww % 2 == 0) ? iss1_valid : iss0_valid), 0);
                chk("R3", "granted warp", int'((ww % 2 == 0) ? iss0_warp : iss1_warp), ww);
                chk("R4", "group", int'((ww % 2 == 0) ? iss0_grp : iss1_grp), grp_of(cc));
                tick();
                chk("R9", "pending cleared", int'(warp_pending[ww]), 0);
                idle(9);
            end
        end

        // R5: occupancy windows
        interval(1, 2, "R5", 2);
        interval(2, 3, "R5", 8);

        // R4 R10: one slice, three arithmetic warps, every cycle
        set_cls(0, 0); set_cls(2, 0); set_cls(4, 0);
        pulse(8'b0001_0101);
        w = int'(iss0_warp);
        chk("R10", "cycle1 valid", int'(iss0_valid), 1);
        chk("R4", "cycle1 core A", int'(iss0_grp), 0);
        tick();
        chk("R10", "cycle2 valid", int'(iss0_valid), 1);
        chk("R10", "cycle2 new warp", int'(int'(iss0_warp) != w), 1);
        chk("R4", "cycle2 core B", int'(iss0_grp), 1);
        tick();
        chk("R10", "cycle3 valid", int'(iss0_valid), 1);
        chk("R4", "cycle3 core A", int'(iss0_grp), 0);
        idle(10);

        // R6: pairings
        set_cls(0, 0); set_cls(1, 0);
        pulse(8'b0000_0011);
        chk("R6", "arith pair both", int'(iss0_valid & iss1_valid), 1);
        chk("R6", "arith pair grp0", int'(iss0_grp), 0);
        chk("R6", "arith pair grp1", int'(iss1_grp), 1);
        idle(10);
        set_cls(0, 1); set_cls(1, 2);
        pulse(8'b0000_0011);
        chk("R6", "mem+sfx both", int'(iss0_valid & iss1_valid), 1);
        chk("R6", "mem+sfx grp0", int'(iss0_grp), 2);
        chk("R6", "mem+sfx grp1", int'(iss1_grp), 3);
        idle(10);
        set_cls(0, 2); set_cls(1, 0);
        pulse(8'b0000_0011);
        chk("R6", "sfx+arith both", int'(iss0_valid & iss1_valid), 1);
        chk("R6", "sfx+arith grp0", int'(iss0_grp), 3);
        chk("R6", "sfx+arith grp1", int'(iss1_grp), 0);
        idle(10);

        // R7: single-group clashes, alternating per class
        do_reset();
        clash_pair(1, "R7");
        clash_pair(1, "R7");
        clash_pair(2, "R7");
        clash_pair(2, "R7");

        // R7: arithmetic clash with one core free
        set_cls(0, 0);
        pulse(8'b0000_0001);
        chk("R7", "lone arith to A", int'(iss0_grp), 0);
        set_cls(2, 0); set_cls(1, 0);
        pulse(8'b0000_0110);
        chk("R7", "arith clash port0 wins", int'(iss0_valid), pri[0] == 0 ? 1 : 0);
        chk("R7", "arith clash port1 waits", int'(iss1_valid), pri[0] == 1 ? 1 : 0);
        chk("R7", "arith clash to core B", int'(pri[0] == 0 ? iss0_grp : iss1_grp), 1);
        tick();
        chk("R7", "arith loser next cycle", int'(pri[0] == 0 ? iss1_valid : iss0_valid), 1);
        chk("R7", "arith loser core A", int'(pri[0] == 0 ? iss1_grp : iss0_grp), 0);
        pri[0] = 1 - pri[0];
        idle(10);

        // R8: round-robin order from the reset pointer
        do_reset();
        for (int i = 0; i < 4; i++) set_cls(2 * i, 1);
        pulse(8'b0101_0101);
        for (int i = 0; i < 4; i++) begin
            next_iss0(w);
            chk("R8", "rotation from reset", w, 2 * i);
            tick();
        end
        idle(6);
        pulse(8'b0001_0100);
        next_iss0(w); chk("R8", "set{2,4} first", w, 2); tick();
        next_iss0(w); chk("R8", "set{2,4} second", w, 4); tick();
        idle(6);
        set_cls(6, 1);
        pulse(8'b0100_0100);
        next_iss0(w); chk("R8", "wrap: 6 before 2", w, 6); tick();
        next_iss0(w); chk("R8", "wrap: then 2", w, 2); tick();
        idle(10);

        // R9: re-ready in the grant cycle keeps the flag
        set_cls(1, 0);
        pulse(8'b0000_0010);
        chk("R9", "first grant", int'(iss1_valid), 1);
        pulse(8'b0000_0010);
        chk("R9", "regranted", int'(iss1_valid), 1);
        chk("R9", "regrant on core B", int'(iss1_grp), 1);
        tick();
        chk("R9", "cleared after regrant", int'(warp_pending[1]), 0);
        idle(4);

        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule